// File: doc/BRIEF.md
# Belt Machine Execute Stage

This block is the execute stage of a processor whose temporary values live on a belt. The belt is a fixed-length queue in which the newest value sits at position 0 and older values move to higher positions. Each 16-bit instruction names up to two source positions on the belt. It never names a destination. A computed result always enters at the front of the belt, and the external operand store shifts its contents by one position to make room.

The stage also moves values between the belt and a small private scratch store:
- Spill copies a belt value into a scratch slot.
- Fill drops a scratch value back at the front of the belt.

Two branch forms exist. The first takes its target from a belt value. The second adds a sign-extended offset from the instruction to the current program counter.

Instructions arrive through a valid/ready handshake. The stage has two states:
- `ST_IDLE` accepts an instruction: transition `accept`, taken when `in_valid && in_ready`.
- `ST_RESULT` presents the outcome for one cycle and then always goes back to `ST_IDLE`: transition `retire`.

While the stage is in `ST_RESULT` it accepts nothing. This gives the operand store one edge to apply a drop before the next instruction reads the belt.

Top module: `belt_exec`

## Requirements
- R1: After reset, `drop_valid`, `redirect_valid` and `illegal` are low, `in_ready` is high, and every scratch slot holds zero.
- R2: The instruction fields are laid out as follows:
  - opcode in bits [15:10];
  - position A in bits [9:5];
  - position B in bits [4:0].
  While `in_valid` is high, `rd_pos_a` and `rd_pos_b` carry the two position fields.
- R3: Opcodes 0 to 4 (add, subtract, AND, OR, XOR of belt[A] with belt[B], modulo 2^32) drop their result. `drop_valid` is high for exactly the one cycle after acceptance, and `drop_data` holds the result in that cycle.
- R4: In the cycle after an instruction is accepted, `in_ready` is low. It is high again in the cycle after that.
- R5: Opcode 5 (spill) stores belt[A] into scratch slot B. It drops nothing and does not redirect.
- R6: Opcode 6 (fill) drops the current contents of scratch slot B, one cycle after acceptance.
- R7: Opcode 7 jumps through a belt value. `redirect_valid` is high for exactly one cycle, `redirect_pc` equals the low 16 bits of belt[A], and nothing is dropped.
- R8: Opcode 8 is a relative branch. `redirect_pc` equals `in_pc` plus the sign-extended 10-bit field formed by bits [9:0], modulo 2^16. It is valid for one cycle, and nothing is dropped.
- R9: Opcodes 9 to 63 raise `illegal` for exactly one cycle. They drop nothing, do not redirect, and leave the scratch store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Stage can accept an instruction |
| in_word | input | 16 | Instruction word |
| in_pc | input | 16 | Program counter of the offered instruction |
| rd_pos_a | output | 5 | Belt position for operand A |
| rd_pos_b | output | 5 | Belt position for operand B |
| rd_data_a | input | 32 | Belt value at `rd_pos_a`, returned in the same cycle |
| rd_data_b | input | 32 | Belt value at `rd_pos_b`, returned in the same cycle |
| drop_valid | output | 1 | Push `drop_data` onto the belt front |
| drop_data | output | 32 | Value to drop |
| redirect_valid | output | 1 | Branch taken |
| redirect_pc | output | 16 | Branch target |
| illegal | output | 1 | Undefined opcode was executed |

## Verification
The bench exercises several corner cases:
- Operands at positions 0 and 31. A design that decoded a field into the wrong bit slice would read the wrong belt value.
- A subtraction that wraps.
- Relative branches with negative offsets. A design that zero-extended the offset would jump forward instead of backward.
- A fill straight after reset and a spill-then-fill round trip. These catch a scratch store with a wrong slot index or a wrong reset value.
- Back-to-back issue. A design that kept `in_ready` high would read the belt before the previous drop had landed.
- Illegal opcodes, which are followed by a fill of a slot they could have written. A design that treated them as spills or drops would shift the bench's belt model.

// File: rtl/belt_pkg.sv
package belt_pkg;

    typedef enum logic [2:0] {
        K_ALU,
        K_SPILL,
        K_FILL,
        K_BABS,
        K_BREL,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR
    } alu_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } state_e;

    typedef struct packed {
        kind_e kind;
        alu_e  alu_op;
    } dec_t;

endpackage

// File: rtl/belt_decode.sv
module belt_decode
    import belt_pkg::*;
#(
    parameter int OPW = 6
) (
    input  logic [OPW-1:0] opcode,
    output dec_t           dec
);
    always_comb begin
        dec.kind   = K_BAD;
        dec.alu_op = ALU_ADD;
        unique case (opcode)
            OPW'(0): begin dec.kind = K_ALU; dec.alu_op = ALU_ADD; end
            OPW'(1): begin dec.kind = K_ALU; dec.alu_op = ALU_SUB; end
            OPW'(2): begin dec.kind = K_ALU; dec.alu_op = ALU_AND; end
            OPW'(3): begin dec.kind = K_ALU; dec.alu_op = ALU_OR;  end
            OPW'(4): begin dec.kind = K_ALU; dec.alu_op = ALU_XOR; end
            OPW'(5): dec.kind = K_SPILL;
            OPW'(6): dec.kind = K_FILL;
            OPW'(7): dec.kind = K_BABS;
            OPW'(8): dec.kind = K_BREL;
            default: dec.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/belt_alu.sv
module belt_alu
    import belt_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/belt_scratch.sv
module belt_scratch #(
    parameter int W     = 32,
    parameter int SLOTW = 5,
    localparam int SLOTS = 1 << SLOTW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SLOTW-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [SLOTW-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en && wr_idx == SLOTW'(s))
                slot_q[s] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/belt_exec.sv
module belt_exec
    import belt_pkg::*;
#(
    parameter int W     = 32,
    parameter int POSW  = 5,
    parameter int PCW   = 16,
    parameter int SLOTW = 5,
    localparam int OPW  = 6,
    localparam int OFFW = 2 * POSW,
    localparam int IW   = OPW + OFFW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IW-1:0]   in_word,
    input  logic [PCW-1:0]  in_pc,
    output logic [POSW-1:0] rd_pos_a,
    output logic [POSW-1:0] rd_pos_b,
    input  logic [W-1:0]    rd_data_a,
    input  logic [W-1:0]    rd_data_b,
    output logic            drop_valid,
    output logic [W-1:0]    drop_data,
    output logic            redirect_valid,
    output logic [PCW-1:0]  redirect_pc,
    output logic            illegal
);
    state_e         state_q, state_d;
    kind_e          kind_q;
    logic [W-1:0]   res_q;
    logic [PCW-1:0] tgt_q;
    dec_t           dec;
    logic [W-1:0]   alu_y;
    logic [W-1:0]   fill_val;
    logic           accept;
    logic [PCW-1:0] rel_off;

    assign rd_pos_a = in_word[OFFW-1:POSW];
    assign rd_pos_b = in_word[POSW-1:0];
    assign accept   = in_valid && in_ready;
    assign rel_off  = {{(PCW-OFFW){in_word[OFFW-1]}}, in_word[OFFW-1:0]};

    belt_decode #(.OPW(OPW)) u_dec (
        .opcode (in_word[IW-1:OFFW]),
        .dec    (dec)
    );

    belt_alu #(.W(W)) u_alu (
        .op (dec.alu_op),
        .a  (rd_data_a),
        .b  (rd_data_b),
        .y  (alu_y)
    );

    belt_scratch #(.W(W), .SLOTW(SLOTW)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && dec.kind == K_SPILL),
        .wr_idx  (rd_pos_b[SLOTW-1:0]),
        .wr_data (rd_data_a),
        .rd_idx  (rd_pos_b[SLOTW-1:0]),
        .rd_data (fill_val)
    );

    // next-state logic: accept then retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_RESULT;
            ST_RESULT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_BAD;
            res_q  <= '0;
            tgt_q  <= '0;
        end else if (accept) begin
            kind_q <= dec.kind;
            res_q  <= (dec.kind == K_FILL) ? fill_val : alu_y;
            tgt_q  <= (dec.kind == K_BREL) ? in_pc + rel_off : rd_data_a[PCW-1:0];
        end
    end

    // outputs
    always_comb begin
        in_ready       = (state_q == ST_IDLE);
        drop_valid     = 1'b0;
        redirect_valid = 1'b0;
        illegal        = 1'b0;
        drop_data      = res_q;
        redirect_pc    = tgt_q;
        if (state_q == ST_RESULT) begin
            unique case (kind_q)
                K_ALU, K_FILL:  drop_valid     = 1'b1;
                K_BABS, K_BREL: redirect_valid = 1'b1;
                K_BAD:          illegal        = 1'b1;
                default:        ;
            endcase
        end
    end

    a_r3_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |=> !drop_valid);
    a_r3_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drop_valid) |-> $past(in_valid && in_ready));
    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    a_r4_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);
    a_r7_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!drop_valid && !redirect_valid));
    a_r5_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_valid && redirect_valid));
endmodule

// File: tb/test_belt_exec.sv
module test_belt_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic [15:0] in_pc = '0;
    logic [4:0]  rd_pos_a, rd_pos_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        drop_valid;
    logic [31:0] drop_data;
    logic        redirect_valid;
    logic [15:0] redirect_pc;
    logic        illegal;

    logic [31:0] belt_m [32];
    logic [31:0] scr_m  [32];
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    belt_exec i_belt_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_pc(in_pc), .rd_pos_a(rd_pos_a), .rd_pos_b(rd_pos_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .drop_valid(drop_valid),
        .drop_data(drop_data), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .illegal(illegal)
    );

    assign rd_data_a = belt_m[rd_pos_a];
    assign rd_data_b = belt_m[rd_pos_b];

    always @(posedge clk) begin
        if (drop_valid) begin
            for (int i = 31; i > 0; i--) belt_m[i] <= belt_m[i-1];
            belt_m[0] <= drop_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] alu_ref(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            6'd0: return a + b;
            6'd1: return a - b;
            6'd2: return a & b;
            6'd3: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic issue(input logic [15:0] w, input logic [15:0] pc);
        logic [5:0]  op = w[15:10];
        logic [4:0]  pa = w[9:5];
        logic [4:0]  pb = w[4:0];
        logic [31:0] va, vb, exp_d;
        logic [15:0] exp_t;
        bit e_drop, e_red, e_ill;
        @(negedge clk);
        va = belt_m[pa];
        vb = belt_m[pb];
        e_drop = 0; e_red = 0; e_ill = 0; exp_d = '0; exp_t = '0;
        if (op <= 6'd4) begin e_drop = 1; exp_d = alu_ref(op, va, vb); end
        else if (op == 6'd6) begin e_drop = 1; exp_d = scr_m[pb]; end
        else if (op == 6'd7) begin e_red = 1; exp_t = va[15:0]; end
        else if (op == 6'd8) begin e_red = 1; exp_t = pc + {{6{w[9]}}, w[9:0]}; end
        else if (op != 6'd5) e_ill = 1;
        chk(in_ready == 1'b1, "R4 ready before issue", 32'(in_ready), 32'd1);
        in_valid = 1'b1; in_word = w; in_pc = pc;
        #1;
        chk(rd_pos_a == pa && rd_pos_b == pb, "R2 read positions",
            {22'd0, rd_pos_a, rd_pos_b}, {22'd0, pa, pb});
        if (op == 6'd5) scr_m[pb] = va;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R4 busy after accept", 32'(in_ready), 32'd0);
        chk(drop_valid == e_drop, (op == 6'd6) ? "R6 fill drop" : "R3/R5 drop_valid",
            32'(drop_valid), 32'(e_drop));
        if (e_drop) chk(drop_data == exp_d, (op == 6'd6) ? "R6 fill value" : "R3 alu result",
                        drop_data, exp_d);
        chk(redirect_valid == e_red, (op == 6'd8) ? "R8 rel redirect" : "R7 redirect_valid",
            32'(redirect_valid), 32'(e_red));
        if (e_red) chk(redirect_pc == exp_t, (op == 6'd8) ? "R8 rel target" : "R7 abs target",
                       32'(redirect_pc), 32'(exp_t));
        chk(illegal == e_ill, "R9 illegal flag", 32'(illegal), 32'(e_ill));
        @(negedge clk);
        chk(!drop_valid && !redirect_valid && !illegal, "R3 single-cycle outputs",
            {29'd0, drop_valid, redirect_valid, illegal}, 32'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            belt_m[i] = $urandom();
            scr_m[i]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!drop_valid && !redirect_valid && !illegal && in_ready, "R1 reset outputs",
            {28'd0, drop_valid, redirect_valid, illegal, in_ready}, 32'd1);
        rst_n = 1'b1;
        // R1: fill right after reset returns zero
        issue({6'd6, 5'd0, 5'd17}, 16'h0);
        // R3 operands at extreme positions, subtract wraps
        belt_m[0] = 32'd1; belt_m[31] = 32'd5;
        issue({6'd1, 5'd0, 5'd31}, 16'h0);
        issue({6'd0, 5'd31, 5'd0}, 16'h0);
        issue({6'd4, 5'd3, 5'd9}, 16'h0);
        // R5/R6 spill then fill round trip
        issue({6'd5, 5'd2, 5'd7}, 16'h0);
        issue({6'd6, 5'd0, 5'd7}, 16'h0);
        // R9 illegal followed by fill of slot it names
        issue({6'd63, 5'd1, 5'd7}, 16'h0);
        issue({6'd6, 5'd0, 5'd7}, 16'h0);
        // R7 absolute, R8 negative and positive relative
        issue({6'd7, 5'd4, 5'd0}, 16'h0);
        issue({6'd8, 10'h3FF}, 16'h0010);
        issue({6'd8, 10'h200}, 16'h0100);
        issue({6'd8, 10'h1FF}, 16'hFF00);
        for (int n = 0; n < 400; n++) begin
            logic [15:0] w;
            w = {6'($urandom_range(0, 12)), 5'($urandom()), 5'($urandom())};
            issue(w, 16'($urandom()));
        end
        finish_run();
    end
endmodule